// File: doc/BRIEF.md
# Legacy-Mode Floppy Controller Register Port

This block is the front end of the older register personality of a floppy controller that offers two personalities. It sits on a plain byte bus with an address, a read strobe, a write strobe, write data and registered read data. The block keeps eight one-bit latches. Every accepted access sets or clears one of them as a side effect. The address slot chooses which latch changes and what value it takes. Three of the latches then name one of eight logical registers, so the register an access reaches depends on the latch history as well as on the current address.

Writes land in an eight-entry byte store, and reads return a fixed pattern. A small detector watches the data written to the set-mode register. When it sees the unlock pattern, it pulses a request to hand over to the enhanced personality and raises a level flag. While that flag is high the port ignores all traffic. A return strobe from the enhanced side drops the flag and clears every latch, which leaves the port ready for a fresh unlock.

Top module: `fdc_legacy_port`

## Requirements
- R1: After reset, every latch, every store byte, the read data, the enhanced flag and the request pulse are all zero.
- R2: The bus address is shifted right by SLOT_SHIFT (9) to form a 4-bit slot, and bits below the shift are ignored. Each accepted read or write copies slot bit 0 into the latch numbered by slot bits 3..1, and leaves the other seven latches as they were. Latches 0..3 are the stepper phases, 4 is motor-on and 5 is drive-select. With no strobe, the latches hold.
- R3: The logical register index is {latch7, latch6, latch4}, and it is taken from the latch values after the current access has updated them.
- R4: One clock after an accepted read, the read data is 0xFF when the index is 0 and 0x00 for any other index. The read data holds between reads.
- R5: An accepted write stores the write data into store byte k, where k is the index. Byte k appears on bits 8k+7..8k of the store output. A write with both strobes high also performs the read.
- R6: Writes to index 6 advance a two-bit step counter when data bit 6 matches the expected value for the current step. The expected values are 1, 0, 1, 1 for steps 0 to 3. A mismatch, or a write to any other index, leaves the counter where it was. A match on step 3 returns the counter to 0, pulses the request output high for exactly one cycle, and sets the enhanced flag. Both changes are visible one clock after that write.
- R7: While the enhanced flag is high, reads and writes change no latch, no store byte, no read data and no counter step, and they raise no request.
- R8: A return strobe while the enhanced flag is high clears the flag and all eight latches one clock later and keeps the store. After that, a complete four-step pattern is needed again. A return strobe while the flag is low does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | SLOT_SHIFT+4 | Byte address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| enh_leave | input | 1 | Return from the enhanced personality |
| latch_q | output | 8 | Current latch bits |
| slot_q | output | 64 | Store bytes, byte k at bits 8k+7..8k |
| enh_active | output | 1 | Enhanced personality owns the bus |
| enh_req | output | 1 | One-cycle hand-over request |

## Verification
The bench builds the block with its defaults: SLOT_SHIFT of 9, which gives a 13-bit address and 16 slots, and the unlock key on data bit 6. At that size the bench can walk the latches through all 256 states one bit at a time, using a different offset inside the slot on each step. It checks the decoded index and the read pattern after every step. Writes then cover all sixteen slots. Directed unlock runs cover the plain pattern, mismatches at each step, writes to other indexes in the middle of a pattern, and traffic and returns on both sides of the hand-over.

// File: rtl/fdc_lp_pkg.sv
package fdc_lp_pkg;
  localparam int DW     = 8;
  localparam int NLATCH = 8;
  localparam int NREG   = 8;
  localparam int IW     = $clog2(NREG);

  // register index from the latch bits
  function automatic logic [IW-1:0] reg_index(input logic [NLATCH-1:0] l);
    return {l[7], l[6], l[4]};
  endfunction

  // set or clear one latch
  function automatic logic [NLATCH-1:0] latch_apply(input logic [NLATCH-1:0] l,
                                                   input logic [2:0] sel,
                                                   input logic v);
    logic [NLATCH-1:0] r;
    r = l;
    r[sel] = v;
    return r;
  endfunction

  // key bit expected at each unlock step: 1,0,1,1
  function automatic logic unlock_expect(input logic [1:0] step);
    return step != 2'd1;
  endfunction
endpackage

// File: rtl/fdc_lp_latches.sv
module fdc_lp_latches
  import fdc_lp_pkg::*;
#(
  parameter int SLOT_SHIFT = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_en,
  input  logic                    clr,
  input  logic [SLOT_SHIFT+3:0]   addr,
  output logic [NLATCH-1:0]       latch_q,
  output logic [NLATCH-1:0]       latch_nx
);
  localparam int SEL_LO = SLOT_SHIFT + 1;

  logic [2:0] sel;
  logic       val;
  logic       unused_low;

  assign sel        = addr[SEL_LO+2:SEL_LO];
  assign val        = addr[SLOT_SHIFT];
  assign unused_low = ^addr[SLOT_SHIFT-1:0];

  assign latch_nx = acc_en ? latch_apply(latch_q, sel, val) : latch_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   latch_q <= '0;
    else if (clr) latch_q <= '0;
    else          latch_q <= latch_nx;
  end
endmodule

// File: rtl/fdc_lp_unlock.sv
module fdc_lp_unlock
  import fdc_lp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  input  logic key_bit,
  output logic done
);
  logic [1:0] step_q;
  logic       hit;

  assign hit  = step_en && (key_bit == unlock_expect(step_q));
  assign done = hit && (step_q == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n)   step_q <= 2'd0;
    else if (hit) step_q <= step_q + 2'd1;  // wraps 3 -> 0 on unlock
  end
endmodule

// File: rtl/fdc_lp_regs.sv
module fdc_lp_regs #(
  parameter int NREG = 8,
  parameter int DW   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(NREG)-1:0]  idx,
  input  logic [DW-1:0]            wdata,
  output logic [NREG*DW-1:0]       slots
);
  localparam int IW = $clog2(NREG);

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    logic [DW-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                        byte_q <= '0;
      else if (we && idx == IW'(g))      byte_q <= wdata;
    end
    assign slots[g*DW +: DW] = byte_q;
  end
endmodule

// File: rtl/fdc_legacy_port.sv
module fdc_legacy_port
  import fdc_lp_pkg::*;
#(
  parameter int SLOT_SHIFT  = 9,
  parameter int KEY_BIT     = 6,
  parameter int SETMODE_IDX = 6,
  parameter int ONES_IDX    = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SLOT_SHIFT+3:0]  bus_addr,
  input  logic                   bus_rd,
  input  logic                   bus_wr,
  input  logic [DW-1:0]          bus_wdata,
  output logic [DW-1:0]          bus_rdata,
  input  logic                   enh_leave,
  output logic [NLATCH-1:0]      latch_q,
  output logic [NREG*DW-1:0]     slot_q,
  output logic                   enh_active,
  output logic                   enh_req
);
  logic              acc_go;
  logic              rd_go;
  logic              wr_go;
  logic              leave_go;
  logic              seq_step;
  logic              seq_done;
  logic [NLATCH-1:0] latch_nx;
  logic [IW-1:0]     cur_idx;

  assign acc_go   = (bus_rd || bus_wr) && !enh_active;
  assign rd_go    = bus_rd && !enh_active;
  assign wr_go    = bus_wr && !enh_active;
  assign leave_go = enh_leave && enh_active;
  assign cur_idx  = reg_index(latch_nx);
  assign seq_step = wr_go && (cur_idx == IW'(SETMODE_IDX));

  fdc_lp_latches #(.SLOT_SHIFT(SLOT_SHIFT)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_en   (acc_go),
    .clr      (leave_go),
    .addr     (bus_addr),
    .latch_q  (latch_q),
    .latch_nx (latch_nx)
  );

  fdc_lp_regs #(.NREG(NREG), .DW(DW)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_go),
    .idx   (cur_idx),
    .wdata (bus_wdata),
    .slots (slot_q)
  );

  fdc_lp_unlock u_unlock (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (seq_step),
    .key_bit (bus_wdata[KEY_BIT]),
    .done    (seq_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_go) bus_rdata <= (cur_idx == IW'(ONES_IDX)) ? '1 : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enh_active <= 1'b0;
      enh_req    <= 1'b0;
    end else begin
      enh_req <= seq_done;
      if (seq_done)      enh_active <= 1'b1;
      else if (leave_go) enh_active <= 1'b0;
    end
  end
endmodule

// File: rtl/fdc_lp_chk.sv
module fdc_lp_chk #(
  parameter int SLOT_SHIFT = 9
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [SLOT_SHIFT+3:0] bus_addr,
  input logic                  bus_rd,
  input logic                  bus_wr,
  input logic [7:0]            bus_rdata,
  input logic                  enh_leave,
  input logic [7:0]            latch_q,
  input logic [63:0]           slot_q,
  input logic                  enh_active,
  input logic                  enh_req,
  input logic                  seq_done
);
  logic       acc_d;
  logic       rd_d;
  logic [2:0] sel_d;
  logic       val_d;
  logic       unused_chk;

  assign unused_chk = ^bus_addr[SLOT_SHIFT-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_d <= 1'b0;
      rd_d  <= 1'b0;
      sel_d <= 3'd0;
      val_d <= 1'b0;
    end else begin
      acc_d <= (bus_rd || bus_wr) && !enh_active;
      rd_d  <= bus_rd && !enh_active;
      sel_d <= bus_addr[SLOT_SHIFT+3:SLOT_SHIFT+1];
      val_d <= bus_addr[SLOT_SHIFT];
    end
  end

  p_latch_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_d |-> latch_q[sel_d] == val_d);

  p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd && !bus_wr && !enh_leave) |=> $stable(latch_q));

  p_read_val_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_d |-> bus_rdata == ((latch_q[7] | latch_q[6] | latch_q[4]) ? 8'h00 : 8'hFF));

  p_req_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> (enh_req && enh_active));

  p_req_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    enh_req |=> !enh_req);

  p_rise_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enh_active) |-> enh_req);

  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_active && !enh_leave) |=> ($stable(latch_q) && $stable(slot_q) && $stable(bus_rdata)));

  p_leave_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_active && enh_leave) |=> (!enh_active && latch_q == 8'h00));
endmodule

bind fdc_legacy_port fdc_lp_chk #(.SLOT_SHIFT(SLOT_SHIFT)) u_chk (.*);

// File: tb/tb_fdc_legacy_port.sv
module tb_fdc_legacy_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        enh_leave = 1'b0;
  logic [7:0]  latch_q;
  logic [63:0] slot_q;
  logic        enh_active;
  logic        enh_req;

  int total = 0;
  int bad   = 0;

  // bench model state
  logic [7:0]  m_lat   = '0;
  logic [63:0] m_slots = '0;
  logic [7:0]  m_rd    = '0;
  logic        m_mode  = 1'b0;
  logic        m_req   = 1'b0;
  int          m_cnt   = 0;
  localparam logic [3:0] KEY_PAT = 4'b1101;  // step0=1 step1=0 step2=1 step3=1

  always #5 clk = ~clk;

  fdc_legacy_port dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .enh_leave(enh_leave), .latch_q(latch_q), .slot_q(slot_q),
    .enh_active(enh_active), .enh_req(enh_req)
  );

  task automatic check(input string tag);
    bit ok;
    ok = (latch_q === m_lat) && (slot_q === m_slots) && (bus_rdata === m_rd)
         && (enh_active === m_mode) && (enh_req === m_req);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: latch=%h/%h slots=%h/%h rdata=%h/%h act=%b/%b req=%b/%b (actual/expected)",
               tag, latch_q, m_lat, slot_q, m_slots, bus_rdata, m_rd,
               enh_active, m_mode, enh_req, m_req);
    end
  endtask

  task automatic acc(input int slot, input int off, input bit rd, input bit wr,
                     input logic [7:0] d, input string tag);
    logic [3:0] s;
    logic [2:0] idx;
    s = slot[3:0];
    @(negedge clk);
    bus_addr  = {s, off[8:0]};
    bus_rd    = rd;
    bus_wr    = wr;
    bus_wdata = d;
    m_req     = 1'b0;
    if (!m_mode) begin
      m_lat[s[3:1]] = s[0];
      idx = {m_lat[7], m_lat[6], m_lat[4]};
      if (rd) m_rd = (idx == 3'd0) ? 8'hFF : 8'h00;
      if (wr) begin
        m_slots[idx*8 +: 8] = d;
        if (idx == 3'd6 && d[6] == KEY_PAT[m_cnt]) begin
          if (m_cnt == 3) begin
            m_cnt = 0; m_mode = 1'b1; m_req = 1'b1;
          end else m_cnt++;
        end
      end
    end
    @(negedge clk);
    bus_rd = 1'b0;
    bus_wr = 1'b0;
    check(tag);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    m_req = 1'b0;
    check(tag);
  endtask

  task automatic leave(input string tag);
    @(negedge clk);
    enh_leave = 1'b1;
    m_req = 1'b0;
    if (m_mode) begin
      m_mode = 1'b0;
      m_lat  = '0;
    end
    @(negedge clk);
    enh_leave = 1'b0;
    check(tag);
  endtask

  // latches 7,6 set and 4 cleared -> index 6
  task automatic aim_setmode();
    acc(13, 5, 1, 0, 8'h00, "R3 aim");
    acc(8, 9, 1, 0, 8'h00, "R3 aim");
    acc(15, 3, 1, 0, 8'h00, "R3 aim");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: run hung (actual running, expected done)");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state");

    // R2/R3/R4: walk all 256 latch states
    for (int s = 0; s < 256; s++) begin
      for (int b = 0; b < 8; b++) begin
        acc(b*2 + ((s >> b) & 1), (s*7 + b*61) & 511, 1, 0, 8'h00, "R2 R3 R4 sweep");
      end
    end
    idle("R2 hold without strobe");

    // R5: writes from every slot, some with both strobes (bit 6 clear)
    for (int k = 0; k < 64; k++) begin
      acc(k % 16, k*11, (k % 4) == 3, 1, 8'((k*53 + 17) & 8'hBF), "R5 store");
    end

    // R6: plain unlock
    aim_setmode();
    acc(15, 0, 0, 1, 8'h40, "R6 step0");
    acc(15, 1, 0, 1, 8'h00, "R6 step1");
    acc(15, 2, 0, 1, 8'h40, "R6 step2");
    acc(15, 3, 0, 1, 8'h4F, "R6 step3 unlock");
    idle("R6 single pulse");

    // R7: traffic ignored while enhanced
    acc(0, 4, 1, 0, 8'h00, "R7 read ignored");
    acc(9, 8, 0, 1, 8'hA5, "R7 write ignored");
    acc(15, 8, 1, 1, 8'h40, "R7 both ignored");
    idle("R7 frozen");

    // R8: return clears latches and flag
    leave("R8 return");
    leave("R8 return while legacy");

    // R6: mismatches and foreign writes inside the pattern
    aim_setmode();
    acc(15, 7, 0, 1, 8'h40, "R6 step0");
    acc(15, 7, 0, 1, 8'h40, "R6 mismatch at step1");
    acc(15, 7, 0, 1, 8'h00, "R6 step1");
    acc(15, 7, 0, 1, 8'h00, "R6 mismatch at step2");
    acc(15, 7, 0, 1, 8'h40, "R6 step2");
    acc(14, 7, 0, 1, 8'h40, "R6 foreign index write");
    acc(15, 7, 0, 1, 8'h00, "R6 mismatch at step3");
    acc(15, 7, 0, 1, 8'hFF, "R6 late unlock");
    idle("R6 pulse ends");
    leave("R8 second return");

    // R8: after return, half a pattern is not enough
    aim_setmode();
    acc(15, 1, 0, 1, 8'h40, "R8 restart step0");
    acc(15, 1, 0, 1, 8'h00, "R8 restart step1");
    acc(15, 1, 1, 1, 8'h40, "R8 restart step2");
    idle("R8 still legacy");
    acc(0, 2, 1, 0, 8'h00, "R4 read after partial");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule